// File: doc/BRIEF.md
# Reloadable Up/Down Interval Timer

This block is an 11-bit interval timer. Software picks the direction of counting, a reload (or ceiling) value, and whether an up-count runs over the full range or stops at the programmed value. Each time the count rolls over, the timer sets a sticky event flag. The flag stays set until software clears it with a write-one strobe. The flag, qualified by an interrupt enable, drives an interrupt line.

Counting advances on tick enables, not on a separate clock. One select input picks the system-rate tick or the low-power-rate tick. A master clock-enable can stop counting altogether. A reload value that software writes passes through a short synchronising pipeline before the counter uses it. The counter therefore runs on the previous value for a few cycles after each change.

Top module: `interval_timer`

## Requirements
- R1: After a synchronous reset, `count` is 0 and both `event_flag` and `irq` are 0. The synchronised reload value is also 0.
- R2: When `count_down` is 0 and `free_run` is 0, every counted tick adds 1 to `count`. A counted tick that finds `count` at or above the effective reload value sets `count` to 0 and counts as a wrap.
- R3: When `count_down` is 0 and `free_run` is 1, the count climbs to 2047 and wraps to 0 on the next counted tick, whatever the reload value is.
- R4: When `count_down` is 1, every counted tick subtracts 1 from `count`. A counted tick that finds `count` at 0 loads the effective reload value instead, and that load counts as a wrap.
- R5: A value driven on `reload` becomes the effective reload value after 3 rising clock edges. Until then the counter uses the value from 3 edges earlier.
- R6: A tick is counted only when `clk_en` is 1 and the selected tick input is 1. `use_sys`=1 selects `sys_tick` and `use_sys`=0 selects `lp_tick`. In any other cycle, an enabled counter keeps its value.
- R7: While `enable` is 0, `count` goes to 0 on the next edge and no wrap occurs. Counting resumes on the first counted tick after `enable` returns to 1.
- R8: A wrap sets `event_flag` on the next edge. The flag stays set until a cycle with `clr_event`=1 and no wrap. When a clear and a wrap fall in the same cycle, the flag stays set.
- R9: `irq` is 1 exactly when `event_flag` is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_tick | input | 1 | Tick enable at system rate |
| lp_tick | input | 1 | Tick enable at low-power rate |
| use_sys | input | 1 | 1 selects sys_tick, 0 selects lp_tick |
| clk_en | input | 1 | Master gate for counting |
| enable | input | 1 | Timer enable; 0 holds the count at zero |
| count_down | input | 1 | 0 counts up, 1 counts down |
| free_run | input | 1 | Up-count wraps at 2047 instead of the reload value |
| irq_en | input | 1 | Interrupt mask, 1 unmasks |
| reload | input | 11 | Reload or ceiling value |
| clr_event | input | 1 | Write-one strobe that clears the event flag |
| count | output | 11 | Live counter value |
| event_flag | output | 1 | Sticky wrap event |
| irq | output | 1 | Masked interrupt line |

## Verification
The assertions check these on every cycle:
- the count holds when no tick is counted;
- the count goes to zero while the timer is disabled;
- each step is plus or minus one away from a wrap;
- the count returns to zero after an up-wrap;
- a wrap always sets the flag, and a clear without a wrap always drops it.

Some behaviours show only across a sequence of cycles, so only the bench scenarios can demonstrate them:
- the three-edge lag of a new reload value;
- the full 2048-step free-running cycle;
- the down-count load of the lagged value;
- the collision of a clear strobe with a wrap.

The bench's reference model covers these cycle by cycle.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    parameter int unsigned CNT_W = 11;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_MAX = '1;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        dir_e dir;
        logic free_run;
    } mode_t;

    typedef struct packed {
        cnt_t value;
        logic wrap;
    } step_t;

    // Next counter value for one counted tick.
    function automatic step_t next_step(cnt_t cur, cnt_t reload_eff, mode_t m);
        step_t s;
        cnt_t  ceiling;
        s.wrap  = 1'b0;
        s.value = cur;
        if (m.dir == DIR_DOWN) begin
            if (cur == '0) begin
                s.value = reload_eff;
                s.wrap  = 1'b1;
            end else begin
                s.value = cur - cnt_t'(1);
            end
        end else begin
            ceiling = m.free_run ? CNT_MAX : reload_eff;
            if (cur >= ceiling) begin
                s.value = '0;
                s.wrap  = 1'b1;
            end else begin
                s.value = cur + cnt_t'(1);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/itmr_tick_sel.sv
module itmr_tick_sel (
    input  logic sys_tick,
    input  logic lp_tick,
    input  logic use_sys,
    input  logic clk_en,
    output logic tick
);
    // The clock mux is modelled as a choice between tick enables.
    always_comb begin
        tick = clk_en & (use_sys ? sys_tick : lp_tick);
    end
endmodule

// File: rtl/itmr_reload_sync.sv
module itmr_reload_sync
    import itmr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  cnt_t reload_in,
    output cnt_t reload_eff
);
    generate
        if (SYNC_STAGES <= 1) begin : g_single
            cnt_t stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= reload_in;
            end
            assign reload_eff = stage_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0][CNT_W-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= {stage_q[SYNC_STAGES-2:0], reload_in};
            end
            assign reload_eff = stage_q[SYNC_STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/itmr_count_core.sv
module itmr_count_core
    import itmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  tick,
    input  mode_t mode,
    input  cnt_t  reload_eff,
    output cnt_t  count,
    output logic  wrap
);
    step_t nxt;
    cnt_t  count_q;

    always_comb begin
        nxt  = next_step(count_q, reload_eff, mode);
        wrap = enable & tick & nxt.wrap;
    end

    always_ff @(posedge clk) begin
        if (rst)           count_q <= '0;
        else if (!enable)  count_q <= '0;
        else if (tick)     count_q <= nxt.value;
    end

    assign count = count_q;

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (enable && !tick) |=> (count_q == $past(count_q)));                 // R6
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (count_q == '0));                                        // R7
    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (enable && tick && mode.dir == DIR_UP && !wrap)
        |=> (count_q == $past(count_q) + cnt_t'(1)));                        // R2
    AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wrap && mode.dir == DIR_UP) |=> (count_q == '0));                   // R3
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (enable && tick && mode.dir == DIR_DOWN && !wrap)
        |=> (count_q == $past(count_q) - cnt_t'(1)));                        // R4
endmodule

// File: rtl/itmr_event_flag.sv
module itmr_event_flag (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= wrap | (flag_q & ~clr);
    end

    assign flag = flag_q;

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag_q);                                                    // R8
    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (clr && !wrap) |=> !flag_q);                                         // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);                                        // R8
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_tick,
    input  logic              lp_tick,
    input  logic              use_sys,
    input  logic              clk_en,
    input  logic              enable,
    input  logic              count_down,
    input  logic              free_run,
    input  logic              irq_en,
    input  logic [CNT_W-1:0]  reload,
    input  logic              clr_event,
    output logic [CNT_W-1:0]  count,
    output logic              event_flag,
    output logic              irq
);
    logic  tick;
    logic  wrap;
    cnt_t  reload_eff;
    mode_t mode;

    always_comb begin
        mode.dir      = dir_e'(count_down);
        mode.free_run = free_run;
    end

    itmr_tick_sel u_tick (
        .sys_tick (sys_tick),
        .lp_tick  (lp_tick),
        .use_sys  (use_sys),
        .clk_en   (clk_en),
        .tick     (tick)
    );

    itmr_reload_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .reload_in  (reload),
        .reload_eff (reload_eff)
    );

    itmr_count_core u_core (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .tick       (tick),
        .mode       (mode),
        .reload_eff (reload_eff),
        .count      (count),
        .wrap       (wrap)
    );

    itmr_event_flag u_evt (
        .clk  (clk),
        .rst  (rst),
        .wrap (wrap),
        .clr  (clr_event),
        .flag (event_flag)
    );

    assign irq = event_flag & irq_en;

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        irq |-> event_flag);                                                 // R9
    AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        (!event_flag && !(enable && tick)) |=> !event_flag);                 // R8
endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC = 2047;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sys_tick = 0, lp_tick = 0, use_sys = 1, clk_en = 1, enable = 0;
    logic count_down = 0, free_run = 0, irq_en = 0, clr_event = 0;
    logic [10:0] reload = '0;
    logic [10:0] count;
    logic event_flag, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model state
    int m_cnt = 0;
    bit m_evt = 0;
    int m_pipe [3] = '{0, 0, 0};

    interval_timer uut (
        .clk(clk), .rst(rst), .sys_tick(sys_tick), .lp_tick(lp_tick),
        .use_sys(use_sys), .clk_en(clk_en), .enable(enable),
        .count_down(count_down), .free_run(free_run), .irq_en(irq_en),
        .reload(reload), .clr_event(clr_event), .count(count),
        .event_flag(event_flag), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_tick();
        return clk_en && (use_sys ? sys_tick : lp_tick);
    endfunction

    // One clock: inputs are stable from the preceding negedge.
    task automatic step(string tag);
        bit wr;
        int lim;
        @(posedge clk);
        wr = 0;
        if (rst) begin
            m_cnt = 0; m_evt = 0; m_pipe = '{0, 0, 0};
        end else begin
            if (!enable) m_cnt = 0;
            else if (model_tick()) begin
                if (count_down) begin
                    if (m_cnt == 0) begin m_cnt = m_pipe[2]; wr = 1; end
                    else m_cnt = m_cnt - 1;
                end else begin
                    lim = free_run ? MAXC : m_pipe[2];
                    if (m_cnt >= lim) begin m_cnt = 0; wr = 1; end
                    else m_cnt = m_cnt + 1;
                end
            end
            m_evt = wr | (m_evt & ~clr_event);
            m_pipe[2] = m_pipe[1];
            m_pipe[1] = m_pipe[0];
            m_pipe[0] = int'(reload);
        end
        @(negedge clk);
        check(tag, int'(count), m_cnt);
        check("R8", int'(event_flag), int'(m_evt));
        check("R9", int'(irq), int'(m_evt & irq_en));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        rst = 1;
        step("R1");
        step("R1");
        rst = 0;
        // R1: reset state
        check("R1", int'(count), 0);
        check("R1", int'(event_flag), 0);
        check("R1", int'(irq), 0);

        // R5 then R2: new reload lags three edges, up count to ceiling
        reload = 11'd5; enable = 1; sys_tick = 1; use_sys = 1; clk_en = 1;
        irq_en = 1;
        for (int i = 0; i < 4; i++) step("R5");
        for (int i = 0; i < 14; i++) begin
            clr_event = (i % 3 == 0);
            step("R2");
        end
        clr_event = 0;
        // R5: lower the ceiling below the count
        reload = 11'd2;
        for (int i = 0; i < 8; i++) step("R5");

        // R3: free run wraps at 2047
        enable = 0; step("R7"); check("R7", int'(count), 0);
        enable = 1; free_run = 1; clr_event = 1; step("R3"); clr_event = 0;
        for (int i = 0; i < 2052; i++) step("R3");

        // R4: down count reloads from zero
        free_run = 0; count_down = 1; reload = 11'd4;
        for (int i = 0; i < 20; i++) step("R4");

        // R6: gating and source selection
        clk_en = 0;
        for (int i = 0; i < 5; i++) step("R6");
        clk_en = 1; use_sys = 0; lp_tick = 0;
        for (int i = 0; i < 5; i++) step("R6");
        lp_tick = 1; sys_tick = 0;
        for (int i = 0; i < 5; i++) step("R6");
        use_sys = 1; sys_tick = 1; lp_tick = 0;

        // R7: disable forces zero, resume
        enable = 0;
        for (int i = 0; i < 3; i++) step("R7");
        enable = 1; count_down = 0;
        for (int i = 0; i < 3; i++) step("R7");

        // R8: clear colliding with a wrap, then a clean clear
        reload = 11'd0;
        for (int i = 0; i < 4; i++) step("R8");
        clr_event = 1; step("R8");
        check("R8", int'(event_flag), 1);
        sys_tick = 0; step("R8");
        check("R8", int'(event_flag), 0);
        clr_event = 0;

        // R9: mask toggling
        sys_tick = 1; step("R9"); sys_tick = 0;
        irq_en = 0; step("R9"); check("R9", int'(irq), 0);
        irq_en = 1; step("R9"); check("R9", int'(irq), 1);

        // Random mix
        for (int blk = 0; blk < 60; blk++) begin
            count_down = $urandom_range(0, 1);
            free_run   = ($urandom_range(0, 7) == 0);
            reload     = 11'($urandom_range(0, 40));
            use_sys    = $urandom_range(0, 1);
            irq_en     = $urandom_range(0, 1);
            for (int i = 0; i < 50; i++) begin
                sys_tick  = ($urandom_range(0, 3) != 0);
                lp_tick   = ($urandom_range(0, 2) == 0);
                clk_en    = ($urandom_range(0, 15) != 0);
                enable    = ($urandom_range(0, 31) != 0);
                clr_event = ($urandom_range(0, 5) == 0);
                if ($urandom_range(0, 19) == 0) reload = 11'($urandom_range(0, 40));
                step("R2");
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule